// File: doc/BRIEF.md
# Pipelined Word Copy Engine

This block moves a run of 32-bit words from one memory region to another over a single memory master port. The port has a read request channel and a write request channel. The memory grants each channel separately, so a read and a write can both complete in one cycle when they fall in different banks. Configuration inputs give the source address, the destination address, the word count and one increment flag per side. A one-cycle start pulse launches the copy. The engine raises `busy` while it runs and pulses `done` when the last write has been accepted.

Internally, an address generator fills two address queues, one for reads and one for writes. Returned read data lands in a data queue, and the write side pairs the head of the write-address queue with the head of the data queue. Each word goes through four stages: read request, read data, write request, write completion. The write of a word therefore leaves two cycles after its read. At most three words may be read and not yet written: one in flight, one in the normal pipeline position, and one in a holding slot. Further reads wait until a write drains the data queue. When reads lose bank conflicts to writes, throughput drops to a steady bubble pattern instead of stopping.

Top module: `dmaCopyEngine`

## Requirements
- R1: After reset, `busy`, `done`, `rdReq` and `wrReq` are all 0.
- R2: With both increment flags at 1, each address advances by 4 bytes per word. After `done`, destination word j holds source word j for every j below the count, and the word just past the destination region is left untouched.
- R3: With the read increment flag at 0, every read uses the source address, so every destination word receives the first source word.
- R4: With the write increment flag at 0, every write goes to the destination address, so it ends up holding the last word read.
- R5: When every request is granted in the cycle it is raised, `done` becomes visible after the (N+3)th clock edge following the edge that samples `cfgStart`, for a count N of at least 1.
- R6: `busy` is 1 from the edge that accepts a nonzero start until the edge that accepts the last write. At that edge `busy` falls and `done` rises for exactly one cycle, and `done` is never 1 while `busy` is 1.
- R7: A start with a count of 0 pulses `done` in the cycle after the sampling edge, leaves `busy` at 0 and raises no memory request.
- R8: A start pulse that arrives while `busy` is 1 is ignored. It causes no access to the addresses it names and no extra `done` pulse.
- R9: A read or write request that is not granted stays raised in the next cycle with the same address (and, for writes, the same data). The copy completes correctly under any pattern of withheld grants.
- R10: Granted reads minus granted writes never exceed 3. With writes withheld from the start of a copy, exactly 3 reads are granted and then reads stop.
- R11: When source and destination differ by 8 modulo 16 bytes and writes win bank conflicts (bank = address bits [3:2]), a copy of N words takes between 1.4N and 1.6N+8 cycles and stays correct.
- R12: No memory request is raised while `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgSrc | input | 32 | Source byte address of the first word |
| cfgDst | input | 32 | Destination byte address of the first word |
| cfgCount | input | CNT_W | Number of words to move |
| cfgIncRd | input | 1 | 1: source address steps by 4 per word |
| cfgIncWr | input | 1 | 1: destination address steps by 4 per word |
| cfgStart | input | 1 | Start pulse, taken only while idle |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle pulse at completion |
| rdReq | output | 1 | Read request |
| rdAddr | output | 32 | Read byte address |
| rdGnt | input | 1 | Read granted this cycle; data follows next cycle |
| rdData | input | 32 | Read data, valid the cycle after a grant |
| wrReq | output | 1 | Write request |
| wrAddr | output | 32 | Write byte address |
| wrData | output | 32 | Write data |
| wrGnt | input | 1 | Write granted this cycle |

## Verification
Stale pointers or a wrong queue index show up as wrong or shifted destination words once `done` fires, and a missing increment repeats one word through the whole region. A lost slot in the three-word read allowance shows at the ports within a few cycles: reads either keep flowing while writes are withheld, or run slower than one word per cycle on a copy without conflicts, so `done` moves off the N+3 edge. A counter that miscounts leaves `busy` high forever or lets it fall with requests still pending, which is visible in the cycle after the last write.

// File: rtl/dmaPkg.sv
package dmaPkg;
  localparam int ADDR_W     = 32;
  localparam int DATA_W     = 32;
  localparam int WORD_BYTES = 4;

  // control -> datapath: one address pair per word to move
  typedef struct packed {
    logic              push;
    logic [ADDR_W-1:0] srcAddr;
    logic [ADDR_W-1:0] dstAddr;
  } genStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic raFull;
    logic waFull;
    logic wrAccept;
  } flowStat_t;
endpackage

// File: rtl/dmaFifo.sv
module dmaFifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       push,
  input  logic                       pop,
  input  logic [WIDTH-1:0]           din,
  output logic [WIDTH-1:0]           dout,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PW-1:0]    wrPtr, rdPtr;
  logic             doPush, doPop;

  always_comb begin
    doPush = push && (count != CW'(DEPTH));
    doPop  = pop && (count != '0);
    dout   = store[rdPtr];
  end

  always_ff @(posedge clk) begin
    if (doPush) store[wrPtr] <= din;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/dmaCtrl.sv
module dmaCtrl
  import dmaPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cfgSrc,
  input  logic [ADDR_W-1:0] cfgDst,
  input  logic [CNT_W-1:0]  cfgCount,
  input  logic              cfgIncRd,
  input  logic              cfgIncWr,
  input  logic              cfgStart,
  input  flowStat_t         flow,
  output genStrobe_t        gen,
  output logic              busy,
  output logic              done
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  logic [CNT_W-1:0]  pushLeft, writeLeft;
  logic [ADDR_W-1:0] srcPtr, dstPtr;
  logic              incRd, incWr;
  logic              accept, canPush;

  always_comb begin
    accept      = cfgStart && !busy;
    canPush     = busy && (pushLeft != '0) && !flow.raFull && !flow.waFull;
    gen.push    = canPush;
    gen.srcAddr = srcPtr;
    gen.dstAddr = dstPtr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      pushLeft  <= '0;
      writeLeft <= '0;
      srcPtr    <= '0;
      dstPtr    <= '0;
      incRd     <= 1'b0;
      incWr     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        if (cfgCount == '0) begin
          done <= 1'b1;
        end else begin
          busy      <= 1'b1;
          pushLeft  <= cfgCount;
          writeLeft <= cfgCount;
          srcPtr    <= cfgSrc;
          dstPtr    <= cfgDst;
          incRd     <= cfgIncRd;
          incWr     <= cfgIncWr;
        end
      end else if (busy) begin
        if (canPush) begin
          pushLeft <= pushLeft - 1'b1;
          if (incRd) srcPtr <= srcPtr + STEP;
          if (incWr) dstPtr <= dstPtr + STEP;
        end
        if (flow.wrAccept) begin
          writeLeft <= writeLeft - 1'b1;
          if (writeLeft == CNT_W'(1)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/dmaData.sv
module dmaData
  import dmaPkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  genStrobe_t        gen,
  output flowStat_t         flow,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic              rdGnt,
  input  logic [DATA_W-1:0] rdData,
  output logic              wrReq,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  input  logic              wrGnt
);
  localparam int CW         = $clog2(FIFO_DEPTH + 1);
  localparam int HOLD_SLOTS = 3;  // in flight + pipeline word + holding slot
  localparam int RQ = 0;
  localparam int WQ = 1;

  logic [ADDR_W-1:0] aIn  [2];
  logic [ADDR_W-1:0] aOut [2];
  logic [CW-1:0]     aCnt [2];
  logic              aPop [2];
  logic [DATA_W-1:0] dOut;
  logic [CW-1:0]     dCnt;
  logic              inflight, rdFire, wrFire;

  for (genvar q = 0; q < 2; q++) begin : gAddrQ
    dmaFifo #(.WIDTH(ADDR_W), .DEPTH(FIFO_DEPTH)) uQ (
      .clk   (clk),
      .rstN  (rstN),
      .push  (gen.push),
      .pop   (aPop[q]),
      .din   (aIn[q]),
      .dout  (aOut[q]),
      .count (aCnt[q])
    );
  end

  dmaFifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) uDataQ (
    .clk   (clk),
    .rstN  (rstN),
    .push  (inflight),
    .pop   (wrFire),
    .din   (rdData),
    .dout  (dOut),
    .count (dCnt)
  );

  always_comb begin
    aIn[RQ]       = gen.srcAddr;
    aIn[WQ]       = gen.dstAddr;
    rdReq         = (aCnt[RQ] != '0) && ((int'(dCnt) + int'(inflight)) < HOLD_SLOTS);
    rdAddr        = aOut[RQ];
    rdFire        = rdReq && rdGnt;
    wrReq         = (aCnt[WQ] != '0) && (dCnt != '0);
    wrAddr        = aOut[WQ];
    wrData        = dOut;
    wrFire        = wrReq && wrGnt;
    aPop[RQ]      = rdFire;
    aPop[WQ]      = wrFire;
    flow.raFull   = (aCnt[RQ] == CW'(FIFO_DEPTH));
    flow.waFull   = (aCnt[WQ] == CW'(FIFO_DEPTH));
    flow.wrAccept = wrFire;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) inflight <= 1'b0;
    else       inflight <= rdFire;
  end
endmodule

// File: rtl/dmaCopyEngine.sv
module dmaCopyEngine
  import dmaPkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [31:0]       cfgSrc,
  input  logic [31:0]       cfgDst,
  input  logic [CNT_W-1:0]  cfgCount,
  input  logic              cfgIncRd,
  input  logic              cfgIncWr,
  input  logic              cfgStart,
  output logic              busy,
  output logic              done,
  output logic              rdReq,
  output logic [31:0]       rdAddr,
  input  logic              rdGnt,
  input  logic [31:0]       rdData,
  output logic              wrReq,
  output logic [31:0]       wrAddr,
  output logic [31:0]       wrData,
  input  logic              wrGnt
);
  genStrobe_t genS;
  flowStat_t  flowS;

  dmaCtrl #(.CNT_W(CNT_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgSrc   (cfgSrc),
    .cfgDst   (cfgDst),
    .cfgCount (cfgCount),
    .cfgIncRd (cfgIncRd),
    .cfgIncWr (cfgIncWr),
    .cfgStart (cfgStart),
    .flow     (flowS),
    .gen      (genS),
    .busy     (busy),
    .done     (done)
  );

  dmaData #(.FIFO_DEPTH(FIFO_DEPTH)) uData (
    .clk    (clk),
    .rstN   (rstN),
    .gen    (genS),
    .flow   (flowS),
    .rdReq  (rdReq),
    .rdAddr (rdAddr),
    .rdGnt  (rdGnt),
    .rdData (rdData),
    .wrReq  (wrReq),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .wrGnt  (wrGnt)
  );
endmodule

// File: rtl/dmaCopyEngineChk.sv
module dmaCopyEngineChk (
  input logic        clk,
  input logic        rstN,
  input logic        cfgIncRd,
  input logic        cfgStart,
  input logic        busy,
  input logic        done,
  input logic        rdReq,
  input logic        rdGnt,
  input logic [31:0] rdAddr,
  input logic        wrReq,
  input logic        wrGnt,
  input logic [31:0] wrAddr,
  input logic [31:0] wrData
);
  logic        latInc, haveRd;
  logic [31:0] lastRd;
  logic [3:0]  outstanding;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latInc      <= 1'b0;
      haveRd      <= 1'b0;
      lastRd      <= '0;
      outstanding <= '0;
    end else begin
      if (cfgStart && !busy) begin
        latInc <= cfgIncRd;
        haveRd <= 1'b0;
      end else if (rdReq && rdGnt) begin
        haveRd <= 1'b1;
        lastRd <= rdAddr;
      end
      outstanding <= outstanding + 4'(rdReq && rdGnt) - 4'(wrReq && wrGnt);
    end
  end

  // R2 and R3: consecutive granted reads step by 4 or stay put
  a_r2_rd_step: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && rdGnt && haveRd) |-> (rdAddr == lastRd + (latInc ? 32'd4 : 32'd0)));

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  a_r9_rd_hold: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdGnt) |=> (rdReq && $stable(rdAddr)));

  a_r9_wr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && !wrGnt) |=> (wrReq && $stable(wrAddr) && $stable(wrData)));

  a_r10_hold_limit: assert property (@(posedge clk) disable iff (!rstN)
    outstanding <= 4'd3);

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!rdReq && !wrReq));
endmodule

bind dmaCopyEngine dmaCopyEngineChk uChk (
  .clk      (clk),
  .rstN     (rstN),
  .cfgIncRd (cfgIncRd),
  .cfgStart (cfgStart),
  .busy     (busy),
  .done     (done),
  .rdReq    (rdReq),
  .rdGnt    (rdGnt),
  .rdAddr   (rdAddr),
  .wrReq    (wrReq),
  .wrGnt    (wrGnt),
  .wrAddr   (wrAddr),
  .wrData   (wrData)
);

// File: tb/dmaCopyEngine_test.sv
`timescale 1ns/1ps
module dmaCopyEngine_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] cfgSrc = '0, cfgDst = '0;
  logic [15:0] cfgCount = '0;
  logic        cfgIncRd = 1'b1, cfgIncWr = 1'b1, cfgStart = 1'b0;
  logic        busy, done, rdReq, wrReq, rdGnt, wrGnt;
  logic [31:0] rdAddr, wrAddr, wrData;
  logic [31:0] rdData = '0;

  logic [31:0] mem [256];
  logic        forceRdBlock = 1'b0, forceWrBlock = 1'b0, stress = 1'b0;
  logic [7:0]  lfsr = 8'h5B;
  int          checks = 0, failures = 0;
  int          doneSeen = 0, reqSeen = 0, rdSeen = 0, cycles = 0;

  always #5 clk = ~clk;

  dmaCopyEngine uut (
    .clk(clk), .rstN(rstN), .cfgSrc(cfgSrc), .cfgDst(cfgDst), .cfgCount(cfgCount),
    .cfgIncRd(cfgIncRd), .cfgIncWr(cfgIncWr), .cfgStart(cfgStart), .busy(busy), .done(done),
    .rdReq(rdReq), .rdAddr(rdAddr), .rdGnt(rdGnt), .rdData(rdData),
    .wrReq(wrReq), .wrAddr(wrAddr), .wrData(wrData), .wrGnt(wrGnt)
  );

  // banked memory model: bank = addr[3:2], writes win conflicts
  always_comb begin
    wrGnt = wrReq && !forceWrBlock && !(stress && lfsr[0]);
    rdGnt = rdReq && !forceRdBlock && !(stress && lfsr[3]) &&
            !(wrGnt && (wrAddr[3:2] == rdAddr[3:2]));
  end

  always @(posedge clk) begin
    if (rdReq && rdGnt) rdData <= mem[rdAddr[9:2]];
    if (wrReq && wrGnt) mem[wrAddr[9:2]] <= wrData;
  end

  always @(negedge clk) begin
    if (done) doneSeen++;
    if (rdReq || wrReq) reqSeen++;
    if (rdReq && rdGnt) rdSeen++;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      failures++;
      $display("FAIL watchdog: run did not finish, actual=%0d expected<150000 cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  function automatic logic [31:0] pat(int i);
    return 32'hC0DE0000 + 32'(i * 7 + 1);
  endfunction

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic check(string req, logic ok, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic startCopy(int src, int dst, int n, logic ir, logic iw);
    tick();
    cfgSrc = 32'(src * 4); cfgDst = 32'(dst * 4); cfgCount = 16'(n);
    cfgIncRd = ir; cfgIncWr = iw; cfgStart = 1'b1;
    tick();
    cfgStart = 1'b0;
  endtask

  task automatic waitDone(output int cyc);
    cyc = 0;
    for (int k = 0; k < 2000; k++) begin
      tick();
      cyc++;
      if (done) break;
    end
  endtask

  task automatic clearDst(int dst, int n);
    for (int j = 0; j <= n; j++) mem[dst + j] = '0;
  endtask

  // returns number of mismatching words (incl. the guard word past the region)
  function automatic int dataErrors(int src, int dst, int n, logic ir, logic iw);
    int bad = 0;
    if (iw) begin
      for (int j = 0; j < n; j++)
        if (mem[dst + j] !== (ir ? pat(src + j) : pat(src))) bad++;
      if (mem[dst + n] !== 32'd0) bad++;
    end else begin
      if (mem[dst] !== (ir ? pat(src + n - 1) : pat(src))) bad++;
      if (mem[dst + 1] !== 32'd0) bad++;
    end
    return bad;
  endfunction

  localparam int NV = 6;
  localparam int V_SRC [NV] = '{0, 1, 0, 5, 10, 0};
  localparam int V_DST [NV] = '{128, 130, 131, 140, 200, 130};
  localparam int V_N   [NV] = '{16, 20, 9, 8, 7, 48};
  localparam int V_IR  [NV] = '{1, 1, 1, 0, 1, 1};
  localparam int V_IW  [NV] = '{1, 1, 1, 1, 0, 1};
  // >0: exact done edge; -1: loose bound; -2: conflict bound
  localparam int V_CYC [NV] = '{19, 23, 12, -1, -1, -2};

  initial begin
    int cyc, d0, r0, bad;
    for (int i = 0; i < 256; i++) mem[i] = pat(i);
    repeat (3) tick();
    // R1 reset state
    check("R1 busy", busy == 1'b0, busy, 0);
    check("R1 done/req", {done, rdReq, wrReq} == 3'b000, {done, rdReq, wrReq}, 0);
    tick();
    rstN = 1'b1;
    tick();
    check("R1 idle after release", {busy, done, rdReq, wrReq} == 4'b0000,
          {busy, done, rdReq, wrReq}, 0);

    // vector table: R2 R3 R4 R5 R6 R11
    for (int v = 0; v < NV; v++) begin
      clearDst(V_DST[v], V_N[v]);
      d0 = doneSeen;
      startCopy(V_SRC[v], V_DST[v], V_N[v], V_IR[v][0], V_IW[v][0]);
      check("R6 busy after start", busy == 1'b1, busy, 1);
      waitDone(cyc);
      bad = dataErrors(V_SRC[v], V_DST[v], V_N[v], V_IR[v][0], V_IW[v][0]);
      if (V_IR[v] == 0)      check("R3 fixed source data", bad == 0, bad, 0);
      else if (V_IW[v] == 0) check("R4 fixed destination data", bad == 0, bad, 0);
      else                   check("R2 copy data", bad == 0, bad, 0);
      check("R6 busy low at done", busy == 1'b0, busy, 0);
      tick();
      check("R6 single done pulse", (doneSeen - d0) == 1, doneSeen - d0, 1);
      if (V_CYC[v] > 0)
        check("R5 done edge", cyc == V_CYC[v], cyc, V_CYC[v]);
      else if (V_CYC[v] == -1)
        check("R5 bounded time", cyc >= V_N[v] + 3 && cyc <= 2 * V_N[v] + 8, cyc, V_N[v] + 3);
      else
        check("R11 conflict timing", cyc >= (14 * V_N[v]) / 10 && cyc <= (16 * V_N[v]) / 10 + 8,
              cyc, (3 * V_N[v]) / 2);
    end

    // R7 zero count
    r0 = reqSeen; d0 = doneSeen;
    startCopy(0, 128, 0, 1'b1, 1'b1);
    check("R7 done pulse", done == 1'b1, done, 1);
    check("R7 busy stays low", busy == 1'b0, busy, 0);
    repeat (8) tick();
    check("R7 no requests", reqSeen == r0, reqSeen - r0, 0);
    check("R7 one done", (doneSeen - d0) == 1, doneSeen - d0, 1);

    // R8 start while busy is ignored
    clearDst(128, 12);
    clearDst(220, 5);
    d0 = doneSeen;
    startCopy(0, 128, 12, 1'b1, 1'b1);
    repeat (3) tick();
    cfgSrc = 32'(20 * 4); cfgDst = 32'(220 * 4); cfgCount = 16'd5; cfgStart = 1'b1;
    tick();
    cfgStart = 1'b0;
    waitDone(cyc);
    repeat (10) tick();
    bad = dataErrors(0, 128, 12, 1'b1, 1'b1);
    check("R8 first copy intact", bad == 0, bad, 0);
    bad = 0;
    for (int j = 0; j < 6; j++) if (mem[220 + j] !== 32'd0) bad++;
    check("R8 ignored region untouched", bad == 0, bad, 0);
    check("R8 one done only", (doneSeen - d0) == 1 && busy == 1'b0, doneSeen - d0, 1);

    // R10 holding limit with writes withheld
    clearDst(192, 10);
    forceWrBlock = 1'b1;
    r0 = rdSeen; d0 = doneSeen;
    startCopy(0, 192, 10, 1'b1, 1'b1);
    repeat (15) tick();
    check("R10 reads stop at three", (rdSeen - r0) == 3, rdSeen - r0, 3);
    check("R10 still busy", busy == 1'b1 && doneSeen == d0, busy, 1);
    forceWrBlock = 1'b0;
    waitDone(cyc);
    bad = dataErrors(0, 192, 10, 1'b1, 1'b1);
    check("R10 data after release", bad == 0, bad, 0);

    // R9 random withheld grants
    clearDst(160, 24);
    stress = 1'b1;
    startCopy(0, 160, 24, 1'b1, 1'b1);
    waitDone(cyc);
    stress = 1'b0;
    bad = dataErrors(0, 160, 24, 1'b1, 1'b1);
    check("R9 data under stalls", bad == 0, bad, 0);
    check("R9 completes", done == 1'b1 && busy == 1'b0, done, 1);

    // R12 quiet after all runs
    r0 = reqSeen;
    repeat (6) tick();
    check("R12 idle quiet", reqSeen == r0, reqSeen - r0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule